// File: doc/BRIEF.md
# Issue Queue Wakeup Scoreboard

This block tracks operand readiness for a small out-of-order issue queue. It keeps one ready bit for each physical register and, for each of its queue slots, a valid bit plus a tag and a ready bit for each of two sources. Instructions arrive on a valid/ready dispatch stream with up to two renamed sources and one renamed destination. Completed results arrive as a single-tag writeback broadcast. The block marks every matching waiting source ready and reports how many were woken. A vector shows which slots hold an instruction whose sources are all ready. An external picker returns a one-hot grant that frees the chosen slot. A slot mask squashes entries.

Waiting is not kept as linked lists. Each slot compares its pending source tags against the broadcast tag, which is the same as walking a producer's list of dependents. Registers flagged as fixed-mapping bypass tracking altogether. A source that became ready while its instruction was in flight is caught by the scoreboard lookup at insertion. A broadcast that lands in the same cycle as the insertion is forwarded. Dispatch back-pressure is simple: `disp_ready` is high whenever at least one slot is free, and it does not depend on `disp_valid`. A transfer happens on a rising clock edge with both high. The writeback broadcast has no ready signal and is always taken.

A new producer must not be assigned to a register that still has waiters. If one is, a sticky error output is raised.

Top module: `iq_wakeup_core`

## Requirements
- R1: After reset, all scoreboard bits read ready, all slots are invalid, `rdy_vec` is 0, `disp_ready` is 1, `chain_err` is 0 and `wake_cnt` is 0 while no broadcast is present.
- R2: `disp_ready` is high exactly when some slot is invalid. `disp_slot` shows the lowest-index invalid slot, and an accepted instruction is written into that slot.
- R3: At insertion, a source is stored as ready if its enable is 0, if its fixed flag is 1, or if the scoreboard bit of its tag is ready. Otherwise it is stored as waiting on that tag.
- R4: A non-fixed broadcast in the same cycle as an insertion whose source uses the broadcast tag makes that source enter already ready.
- R5: An accepted instruction with an enabled, non-fixed destination clears that register's scoreboard bit to not-ready. If a broadcast of the same tag falls in the same cycle, the clear wins.
- R6: Fixed-mapping registers are skipped. A fixed source never waits. A fixed destination leaves the scoreboard unchanged and never raises the error. A broadcast with `wb_fix` = 1 wakes nothing, gives `wake_cnt` = 0 and leaves the scoreboard unchanged.
- R7: A non-fixed broadcast marks ready every waiting source of a valid slot whose tag matches, and sets that register's scoreboard bit. In the same cycle, `wake_cnt` equals the number of source fields woken, so a slot waiting twice on the tag counts 2.
- R8: Bit i of `rdy_vec` is 1 exactly when slot i is valid and both of its sources are ready. It appears in the cycle after the insertion or wakeup that completes it. An instruction with no sources, or only fixed sources, is ready in the cycle after insertion.
- R9: A grant bit invalidates its slot at the clock edge. The slot is absent from `rdy_vec` and is free for dispatch from the next cycle.
- R10: A squash invalidates the masked slots, so their pending sources are no longer counted by later broadcasts. An insertion into a slot named in the same cycle's mask takes precedence over the squash.
- R11: `chain_err` becomes 1 after an accepted instruction's enabled, non-fixed destination tag matches a waiting source of a valid slot that the same cycle's broadcast does not wake. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch instruction present |
| disp_ready | output | 1 | A free slot exists |
| disp_slot | output | 3 | Slot the next accepted instruction will occupy |
| disp_s0_en | input | 1 | Source 0 present |
| disp_s0_tag | input | 5 | Source 0 physical register |
| disp_s0_fix | input | 1 | Source 0 is fixed-mapping |
| disp_s1_en | input | 1 | Source 1 present |
| disp_s1_tag | input | 5 | Source 1 physical register |
| disp_s1_fix | input | 1 | Source 1 is fixed-mapping |
| disp_d_en | input | 1 | Destination present |
| disp_d_tag | input | 5 | Destination physical register |
| disp_d_fix | input | 1 | Destination is fixed-mapping |
| wb_valid | input | 1 | Completion broadcast present |
| wb_tag | input | 5 | Completed destination register |
| wb_fix | input | 1 | Completed register is fixed-mapping |
| wake_cnt | output | 5 | Source fields woken by this cycle's broadcast |
| rdy_vec | output | 8 | Slots with all sources ready |
| iss_grant | input | 8 | One-hot grant among ready slots |
| sq_mask | input | 8 | Slots to squash |
| chain_err | output | 1 | Sticky: producer assigned while register had waiters |

## Verification
The functions that can coincide are a writeback broadcast and a dispatch that names the same register. The broadcast may meet a new source, which must enter ready through forwarding. It may meet a new destination, where the scoreboard clear must win and the error must not count waiters that the same broadcast wakes. Directed steps set up each collision on purpose. The random phase draws tags from a narrow range, so broadcasts, dispatches, grants and squashes land on shared registers and slots in the same cycle. A bench reference model built from the requirements then judges the ready vector, wake count, slot choice and error flag every cycle.

// File: rtl/iqw_pkg.sv
package iqw_pkg;
  // sources carried by each queue slot
  localparam int NSRC = 2;

  // a source operand needs tracking only when present and renamed normally
  function automatic logic op_tracked(input logic en, input logic fix);
    return en & ~fix;
  endfunction
endpackage

// File: rtl/iqw_scoreboard.sv
module iqw_scoreboard
  import iqw_pkg::*;
#(
  parameter int NUM_PREG = 32,
  localparam int TAG_W = $clog2(NUM_PREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [TAG_W-1:0]           set_tag,
  input  logic                       clr_en,
  input  logic [TAG_W-1:0]           clr_tag,
  input  logic [NSRC-1:0][TAG_W-1:0] look_tag,
  output logic [NSRC-1:0]            look_rdy
);
  logic [NUM_PREG-1:0] sb_q;

  // one ready bit per physical register; a new producer beats a completion
  for (genvar r = 0; r < NUM_PREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        sb_q[r] <= 1'b1;
      else if (clr_en && clr_tag == TAG_W'(r))
        sb_q[r] <= 1'b0;
      else if (set_en && set_tag == TAG_W'(r))
        sb_q[r] <= 1'b1;
    end
  end

  // lookup with same-cycle completion forwarding
  for (genvar s = 0; s < NSRC; s++) begin : g_look
    assign look_rdy[s] = sb_q[look_tag[s]] | (set_en && look_tag[s] == set_tag);
  end
endmodule

// File: rtl/iqw_entry.sv
module iqw_entry
  import iqw_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc,
  input  logic [NSRC-1:0][TAG_W-1:0] new_tag,
  input  logic [NSRC-1:0]            new_rdy,
  input  logic                       wake_en,
  input  logic [TAG_W-1:0]           wake_tag,
  input  logic                       kill,
  output logic                       valid,
  output logic                       ready,
  output logic [NSRC-1:0]            pend,
  output logic [NSRC-1:0]            woke,
  output logic [NSRC-1:0][TAG_W-1:0] tag
);
  logic                       val_q;
  logic [NSRC-1:0]            rdy_q;
  logic [NSRC-1:0][TAG_W-1:0] tag_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign pend[s] = val_q & ~rdy_q[s];
    assign woke[s] = pend[s] & wake_en & (tag_q[s] == wake_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      rdy_q <= '0;
      tag_q <= '0;
    end else if (alloc) begin
      val_q <= 1'b1;
      rdy_q <= new_rdy;
      tag_q <= new_tag;
    end else begin
      if (kill)
        val_q <= 1'b0;
      rdy_q <= rdy_q | woke;
    end
  end

  assign valid = val_q;
  assign ready = val_q & (&rdy_q);
  assign tag   = tag_q;
endmodule

// File: rtl/iqw_alloc.sv
module iqw_alloc #(
  parameter int NUM_ENT = 8,
  localparam int ENT_W = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0] free_vec,
  output logic               any_free,
  output logic [ENT_W-1:0]   idx
);
  // lowest-index free slot wins
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        any_free = 1'b1;
        idx      = ENT_W'(i);
      end
    end
  end
endmodule

// File: rtl/iq_wakeup_core.sv
module iq_wakeup_core
  import iqw_pkg::*;
#(
  parameter int NUM_ENT  = 8,
  parameter int NUM_PREG = 32,
  localparam int TAG_W = $clog2(NUM_PREG),
  localparam int ENT_W = $clog2(NUM_ENT),
  localparam int CNT_W = $clog2(NSRC * NUM_ENT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_valid,
  output logic               disp_ready,
  output logic [ENT_W-1:0]   disp_slot,
  input  logic               disp_s0_en,
  input  logic [TAG_W-1:0]   disp_s0_tag,
  input  logic               disp_s0_fix,
  input  logic               disp_s1_en,
  input  logic [TAG_W-1:0]   disp_s1_tag,
  input  logic               disp_s1_fix,
  input  logic               disp_d_en,
  input  logic [TAG_W-1:0]   disp_d_tag,
  input  logic               disp_d_fix,
  input  logic               wb_valid,
  input  logic [TAG_W-1:0]   wb_tag,
  input  logic               wb_fix,
  output logic [CNT_W-1:0]   wake_cnt,
  output logic [NUM_ENT-1:0] rdy_vec,
  input  logic [NUM_ENT-1:0] iss_grant,
  input  logic [NUM_ENT-1:0] sq_mask,
  output logic               chain_err
);
  logic wb_act, disp_fire, dst_track;
  logic [NSRC-1:0][TAG_W-1:0] new_tag;
  logic [NSRC-1:0]            new_en, new_fix, look_rdy, new_rdy;
  logic [NUM_ENT-1:0]         ent_val;
  logic [NUM_ENT-1:0][NSRC-1:0] ent_pend, ent_woke;
  logic [NUM_ENT-1:0][NSRC-1:0][TAG_W-1:0] ent_tag;
  logic conflict, err_q;

  assign wb_act    = op_tracked(wb_valid, wb_fix);
  assign disp_fire = disp_valid & disp_ready;
  assign dst_track = disp_fire & op_tracked(disp_d_en, disp_d_fix);

  assign new_tag = {disp_s1_tag, disp_s0_tag};
  assign new_en  = {disp_s1_en, disp_s0_en};
  assign new_fix = {disp_s1_fix, disp_s0_fix};

  iqw_scoreboard #(.NUM_PREG(NUM_PREG)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (wb_act),
    .set_tag  (wb_tag),
    .clr_en   (dst_track),
    .clr_tag  (disp_d_tag),
    .look_tag (new_tag),
    .look_rdy (look_rdy)
  );

  // a source is born ready unless it is tracked and its producer is pending
  for (genvar s = 0; s < NSRC; s++) begin : g_newsrc
    assign new_rdy[s] = ~op_tracked(new_en[s], new_fix[s]) | look_rdy[s];
  end

  iqw_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
    .free_vec (~ent_val),
    .any_free (disp_ready),
    .idx      (disp_slot)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    iqw_entry #(.TAG_W(TAG_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (disp_fire && disp_slot == ENT_W'(e)),
      .new_tag  (new_tag),
      .new_rdy  (new_rdy),
      .wake_en  (wb_act),
      .wake_tag (wb_tag),
      .kill     (iss_grant[e] | sq_mask[e]),
      .valid    (ent_val[e]),
      .ready    (rdy_vec[e]),
      .pend     (ent_pend[e]),
      .woke     (ent_woke[e]),
      .tag      (ent_tag[e])
    );
  end

  // dependents woken, and waiters left on a register given a new producer
  always_comb begin
    wake_cnt = '0;
    conflict = 1'b0;
    for (int e = 0; e < NUM_ENT; e++) begin
      for (int s = 0; s < NSRC; s++) begin
        wake_cnt = wake_cnt + CNT_W'(ent_woke[e][s]);
        if (ent_pend[e][s] && !ent_woke[e][s] && ent_tag[e][s] == disp_d_tag)
          conflict = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (dst_track && conflict)
      err_q <= 1'b1;
  end

  assign chain_err = err_q;
endmodule

// File: rtl/iqw_checker.sv
module iqw_checker #(
  parameter int NUM_ENT = 8,
  parameter int TAG_W = 5,
  parameter int ENT_W = 3,
  parameter int CNT_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic               disp_ready,
  input logic [ENT_W-1:0]   disp_slot,
  input logic               disp_s0_en,
  input logic [TAG_W-1:0]   disp_s0_tag,
  input logic               disp_s0_fix,
  input logic               disp_s1_en,
  input logic [TAG_W-1:0]   disp_s1_tag,
  input logic               disp_s1_fix,
  input logic               wb_valid,
  input logic [TAG_W-1:0]   wb_tag,
  input logic               wb_fix,
  input logic [CNT_W-1:0]   wake_cnt,
  input logic [NUM_ENT-1:0] rdy_vec,
  input logic [NUM_ENT-1:0] iss_grant,
  input logic [NUM_ENT-1:0] sq_mask,
  input logic               chain_err
);
  p_grant_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant != '0) |=> ((rdy_vec & $past(iss_grant)) == '0));

  p_squash_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sq_mask != '0) && !(disp_valid && disp_ready))
      |=> ((rdy_vec & $past(sq_mask)) == '0));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chain_err |=> chain_err);

  p_no_wake_without_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && !wb_fix) |-> (wake_cnt == '0));

  p_forward_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && wb_valid && !wb_fix
      && (!disp_s0_en || disp_s0_fix || disp_s0_tag == wb_tag)
      && (!disp_s1_en || disp_s1_fix || disp_s1_tag == wb_tag))
      |=> rdy_vec[$past(disp_slot)]);
endmodule

bind iq_wakeup_core iqw_checker #(
  .NUM_ENT (NUM_ENT),
  .TAG_W   (TAG_W),
  .ENT_W   (ENT_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_valid  (disp_valid),
  .disp_ready  (disp_ready),
  .disp_slot   (disp_slot),
  .disp_s0_en  (disp_s0_en),
  .disp_s0_tag (disp_s0_tag),
  .disp_s0_fix (disp_s0_fix),
  .disp_s1_en  (disp_s1_en),
  .disp_s1_tag (disp_s1_tag),
  .disp_s1_fix (disp_s1_fix),
  .wb_valid    (wb_valid),
  .wb_tag      (wb_tag),
  .wb_fix      (wb_fix),
  .wake_cnt    (wake_cnt),
  .rdy_vec     (rdy_vec),
  .iss_grant   (iss_grant),
  .sq_mask     (sq_mask),
  .chain_err   (chain_err)
);

// File: tb/tb_iq_wakeup_core.sv
`timescale 1ns/1ps
module tb_iq_wakeup_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_valid = 0, s0en = 0, s0fix = 0, s1en = 0, s1fix = 0, den = 0, dfix = 0;
  logic [4:0] s0tag = 0, s1tag = 0, dtag = 0, wtag = 0;
  logic wvalid = 0, wfix = 0;
  logic [7:0] grant = 0, sq = 0;
  logic disp_ready, chain_err;
  logic [2:0] disp_slot;
  logic [4:0] wake_cnt;
  logic [7:0] rdy_vec;

  int n_chk = 0, n_err = 0;

  // reference model
  bit         m_val [8];
  bit         m_rdy [8][2];
  logic [4:0] m_tag [8][2];
  bit         m_sb  [32];
  bit         m_err;

  always #2.5 clk = ~clk;

  iq_wakeup_core dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(d_valid), .disp_ready(disp_ready),
    .disp_slot(disp_slot), .disp_s0_en(s0en), .disp_s0_tag(s0tag), .disp_s0_fix(s0fix),
    .disp_s1_en(s1en), .disp_s1_tag(s1tag), .disp_s1_fix(s1fix), .disp_d_en(den),
    .disp_d_tag(dtag), .disp_d_fix(dfix), .wb_valid(wvalid), .wb_tag(wtag), .wb_fix(wfix),
    .wake_cnt(wake_cnt), .rdy_vec(rdy_vec), .iss_grant(grant), .sq_mask(sq),
    .chain_err(chain_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_val[i] = 0; m_rdy[i][0] = 0; m_rdy[i][1] = 0; m_tag[i][0] = 0; m_tag[i][1] = 0;
    end
    for (int r = 0; r < 32; r++) m_sb[r] = 1;
    m_err = 0;
  endtask

  function automatic logic [7:0] exp_rdy();
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v[i] = m_val[i] & m_rdy[i][0] & m_rdy[i][1];
    return v;
  endfunction

  task automatic idle();
    d_valid = 0; s0en = 0; s0fix = 0; s1en = 0; s1fix = 0; den = 0; dfix = 0;
    s0tag = 0; s1tag = 0; dtag = 0; wvalid = 0; wtag = 0; wfix = 0; grant = 0; sq = 0;
  endtask

  task automatic disp(input bit e0, input int t0, input bit f0, input bit e1, input int t1,
                      input bit f1, input bit ed, input int td, input bit fd);
    d_valid = 1; s0en = e0; s0tag = 5'(t0); s0fix = f0; s1en = e1; s1tag = 5'(t1);
    s1fix = f1; den = ed; dtag = 5'(td); dfix = fd;
  endtask

  // one cycle: compare outputs with the model, then advance the model at the edge
  task automatic step();
    bit any, fire, wact, econ;
    int idx, cnt;
    bit nr[2];
    bit hit[8][2];
    #1;
    chk("R8 ready vector", rdy_vec, exp_rdy());
    any = 0; idx = 0;
    for (int i = 7; i >= 0; i--) if (!m_val[i]) begin any = 1; idx = i; end
    chk("R2 dispatch ready", disp_ready, any);
    if (any) chk("R2 lowest free slot", disp_slot, idx);
    wact = wvalid && !wfix;
    cnt = 0;
    for (int i = 0; i < 8; i++)
      for (int s = 0; s < 2; s++) begin
        hit[i][s] = wact && m_val[i] && !m_rdy[i][s] && m_tag[i][s] == wtag;
        if (hit[i][s]) cnt++;
      end
    chk("R7 wake count", wake_cnt, cnt);
    chk("R11 error flag", chain_err, m_err);
    fire = d_valid && any;
    nr[0] = !s0en || s0fix || m_sb[s0tag] || (wact && s0tag == wtag);
    nr[1] = !s1en || s1fix || m_sb[s1tag] || (wact && s1tag == wtag);
    econ = 0;
    if (fire && den && !dfix)
      for (int i = 0; i < 8; i++)
        for (int s = 0; s < 2; s++)
          if (m_val[i] && !m_rdy[i][s] && !hit[i][s] && m_tag[i][s] == dtag) econ = 1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 2; s++) if (hit[i][s]) m_rdy[i][s] = 1;
      if (grant[i] || sq[i]) m_val[i] = 0;
    end
    if (fire) begin
      m_val[idx] = 1;
      m_rdy[idx][0] = nr[0]; m_rdy[idx][1] = nr[1];
      m_tag[idx][0] = s0tag; m_tag[idx][1] = s1tag;
    end
    if (wact) m_sb[wtag] = 1;
    if (fire && den && !dfix) m_sb[dtag] = 0;
    if (econ) m_err = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    chk("R1 reset rdy_vec", rdy_vec, 0);
    chk("R1 reset disp_ready", disp_ready, 1);
    chk("R1 reset chain_err", chain_err, 0);
    chk("R1 reset wake_cnt", wake_cnt, 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    model_reset();
    do_reset();

    // R3: fresh scoreboard, both sources ready at once
    disp(1, 3, 0, 1, 7, 0, 1, 10, 0); step(); idle();
    chk("R3 ready after insert", rdy_vec, 8'h01);
    // R5: source on a register just given a producer waits
    disp(1, 10, 0, 0, 0, 0, 1, 11, 0); step(); idle();
    chk("R5 waiter not ready", rdy_vec, 8'h01);
    // R6: fixed source and fixed destination skipped
    disp(1, 10, 1, 0, 0, 0, 1, 10, 1); step(); idle();
    chk("R6 fixed source ready", rdy_vec, 8'h05);
    chk("R6 fixed dest no error", chain_err, 0);
    wvalid = 1; wtag = 10; wfix = 1; #1;
    chk("R6 fixed broadcast wakes none", wake_cnt, 0);
    step(); idle();
    chk("R6 waiter still pending", rdy_vec, 8'h05);
    // R7 + R9: broadcast with grant of slot 0
    wvalid = 1; wtag = 10; grant = 8'h01; #1;
    chk("R7 one dependent woken", wake_cnt, 1);
    step(); idle();
    chk("R9 R7 grant frees, waiter ready", rdy_vec, 8'h06);
    // R4: forwarding of same-cycle broadcast
    disp(0, 0, 0, 0, 0, 0, 1, 20, 0); step(); idle();
    disp(1, 20, 0, 1, 20, 0, 1, 22, 0); wvalid = 1; wtag = 20; #1;
    chk("R4 no waiter to count", wake_cnt, 0);
    step(); idle();
    chk("R4 forwarded source ready", rdy_vec, 8'h0F);
    // R10: squash removes a waiter
    disp(0, 0, 0, 0, 0, 0, 1, 25, 0); step(); idle();
    disp(1, 25, 0, 0, 0, 0, 1, 26, 0); step(); idle();
    chk("R10 waiter inserted", rdy_vec, 8'h1F);
    sq = 8'h20; step(); idle();
    #1;
    chk("R10 squashed slot freed", disp_slot, 5);
    wvalid = 1; wtag = 25; #1;
    chk("R10 squashed waiter not woken", wake_cnt, 0);
    step(); idle();
    // R11: producer reassigned while a waiter remains
    disp(0, 0, 0, 0, 0, 0, 1, 28, 0); step(); idle();
    disp(1, 28, 0, 0, 0, 0, 1, 29, 0); step(); idle();
    disp(0, 0, 0, 0, 0, 0, 1, 28, 0); step(); idle();
    chk("R11 error raised", chain_err, 1);
    chk("R2 full queue not ready", disp_ready, 0);
    step();
    chk("R11 error sticky", chain_err, 1);
    grant = 8'h01; step(); idle(); #1;
    chk("R9 granted slot reusable", disp_slot, 0);
    chk("R9 dispatch ready again", disp_ready, 1);
    @(negedge clk);

    // random phase
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] rv;
      int nrdy, pick;
      d_valid = ($urandom % 10) < 6;
      s0en = ($urandom % 4) != 0; s0tag = 5'($urandom % 16); s0fix = ($urandom % 10) == 0;
      s1en = ($urandom % 4) != 0; s1tag = 5'($urandom % 16); s1fix = ($urandom % 10) == 0;
      den = ($urandom % 5) != 0; dtag = 5'($urandom % 16); dfix = ($urandom % 10) == 0;
      wvalid = $urandom % 2; wtag = 5'($urandom % 16); wfix = ($urandom % 10) == 0;
      rv = exp_rdy(); grant = 0;
      nrdy = $countones(rv);
      if (nrdy != 0 && ($urandom % 2)) begin
        pick = $urandom % nrdy;
        for (int i = 0; i < 8; i++)
          if (rv[i]) begin
            if (pick == 0) grant = 8'(1 << i);
            pick--;
          end
      end
      sq = (($urandom % 20) == 0) ? 8'($urandom) : 8'h00;
      step();
    end
    idle();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule